// File: doc/BRIEF.md
# ROM Table Lookup Sequencer

This block carries out the table-read instruction of a small 4-bit microcontroller core. The operand of that instruction is a 4-bit page number. When the core issues it, the sequencer builds a program-memory address from three parts: the page, the low three bits of the data pointer, and the 4-bit accumulator. It saves the current program counter on the hardware return stack and redirects the program counter to the built address.

It then reads one 9-bit word from program memory. The upper nibble of that word goes to register B and the lower nibble goes to the accumulator. If the upper-ROM-select mode flag has been set, the ninth bit is also written to the carry flag. Finally the sequencer pops the stack, so the program counter returns to where it was. The whole sequence takes three cycles.

The return stack lives in this block, so the core's subroutine call and return also go through it while the sequencer is idle. The core watches `busy` to stall its own fetch. A one-cycle `done` marks the last cycle of the lookup.

Top module: `rom_lookup_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pcLoad`, `romRdEn`, `wrAB`, `wrCy` and `overflow` are 0. The stack is empty and the mode flag is 0.
- R2: When `start` is sampled while idle, `busy` is high for exactly the next three cycles. `done` is high only in the third of them.
- R3: In the first busy cycle, `pcLoad` is 1 and `pcOut` holds the formed address. Bits 10:7 are the page, bits 6:4 are `dptr`, and bits 3:0 are `acc`, all taken at the `start` edge. In the same step, `pcIn` is pushed on the stack.
- R4: In the second busy cycle, `romRdEn` is 1 and `romAddr` equals the formed address. `romData` is expected one cycle after the read.
- R5: In the third busy cycle, `wrAB` is 1, `bOut` equals `romData[7:4]` and `aOut` equals `romData[3:0]`.
- R6: In the third busy cycle, `wrCy` is 1 and `cyOut` equals `romData[8]` when the mode flag is 1. When the flag is 0, `wrCy` stays 0 and carry is left unchanged.
- R7: `ursSet` sets the mode flag from the next cycle onward, and only reset clears it. If `ursSet` is sampled together with `start`, it already applies to that lookup.
- R8: In the third busy cycle, `pcLoad` is 1 and `pcOut` is the value popped from the stack. A lookup therefore leaves the stack depth unchanged.
- R9: While idle, `callPush` pushes `pcIn`. `retPop` pops the stack, and the next cycle shows `pcLoad` with the popped value. `retPop` on an empty stack produces no `pcLoad`.
- R10: A push when the stack holds `STACK_DEPTH` entries writes nothing and sets the sticky `overflow`. A lookup started on a full stack then pops and returns the top entry, which is the last call's value.
- R11: `start`, `callPush` and `retPop` have no effect while `busy` is high.
- R12: When idle, `start` has priority over `callPush`, which has priority over `retPop`. The lower-priority requests sampled in the same cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue the table-read instruction |
| page | input | 4 | Page operand of the instruction |
| dptr | input | 3 | Low bits of the data pointer |
| acc | input | 4 | Current accumulator |
| pcIn | input | 11 | Current program counter, value to push |
| callPush | input | 1 | Subroutine call push request |
| retPop | input | 1 | Subroutine return pop request |
| ursSet | input | 1 | Set the upper-ROM-select mode flag |
| romRdEn | output | 1 | Program-memory read enable |
| romAddr | output | 11 | Program-memory read address |
| romData | input | 9 | Program-memory word, one cycle after the read |
| busy | output | 1 | Lookup in progress, core stalls |
| done | output | 1 | Last cycle of the lookup |
| pcLoad | output | 1 | Load program counter strobe |
| pcOut | output | 11 | New program counter value |
| wrAB | output | 1 | Write strobe for B and accumulator |
| bOut | output | 4 | Value for register B |
| aOut | output | 4 | Value for the accumulator |
| wrCy | output | 1 | Carry write strobe |
| cyOut | output | 1 | Value for carry |
| overflow | output | 1 | Sticky stack overflow flag |

## Verification
Two cases put a second function into the cycle where a lookup is accepted.

The first case raises `ursSet` on the same edge as `start`. Because the flag is consulted only in the third cycle, the bench expects a carry write for that very lookup, and it compares `cyOut` against bit 8 of the word its own ROM model returned.

The second case raises `callPush` and `retPop` together with `start`, and again during the busy cycles. The bench judges this through the program-counter values that later returns pop. Any stray push or pop shifts every one of those values.

// File: rtl/rom_lookup_pkg.sv
package rom_lookup_pkg;
  localparam int PAGE_W = 4;
  localparam int DPTR_W = 3;
  localparam int NIB_W  = 4;
  localparam int LOW_W  = DPTR_W + NIB_W;
  localparam int PC_W   = PAGE_W + LOW_W;
  localparam int ROM_W  = 2 * NIB_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FORM,
    ST_READ,
    ST_TAKE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic pushPc;
    logic formAddr;
    logic popPc;
    logic readRom;
    logic takeWord;
  } seqStrobe_t;
endpackage

// File: rtl/rom_lookup_ctrl.sv
module rom_lookup_ctrl
  import rom_lookup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       callPush,
  input  logic       retPop,
  input  logic       stackEmpty,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       done
);
  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.pushPc   = 1'b1;
          strb.formAddr = 1'b1;
          stateNext     = ST_FORM;
        end else if (callPush) begin
          strb.pushPc = 1'b1;
        end else if (retPop && !stackEmpty) begin
          strb.popPc = 1'b1;
        end
      end
      ST_FORM: stateNext = ST_READ;
      ST_READ: begin
        strb.readRom = 1'b1;
        strb.popPc   = 1'b1;
        stateNext    = ST_TAKE;
      end
      ST_TAKE: begin
        strb.takeWord = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_TAKE);
endmodule

// File: rtl/rom_lookup_dp.sv
module rom_lookup_dp
  import rom_lookup_pkg::*;
#(
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [PAGE_W-1:0] page,
  input  logic [DPTR_W-1:0] dptr,
  input  logic [NIB_W-1:0]  acc,
  input  logic [PC_W-1:0]   pcIn,
  input  logic              ursSet,
  input  logic [ROM_W-1:0]  romData,
  output logic              stackEmpty,
  output logic              romRdEn,
  output logic [PC_W-1:0]   romAddr,
  output logic              pcLoad,
  output logic [PC_W-1:0]   pcOut,
  output logic              wrAB,
  output logic [NIB_W-1:0]  bOut,
  output logic [NIB_W-1:0]  aOut,
  output logic              wrCy,
  output logic              cyOut,
  output logic              overflow
);
  localparam int SP_W  = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W = $clog2(STACK_DEPTH);

  logic [PC_W-1:0]  stackMem [STACK_DEPTH];
  logic [SP_W-1:0]  sp;
  logic [IDX_W-1:0] wrIdx, topIdx;
  logic             stackFull;
  logic [PC_W-1:0]  formed;
  logic [PC_W-1:0]  addrReg;
  logic             ursFlag;

  assign stackFull  = (sp == SP_W'(STACK_DEPTH));
  assign stackEmpty = (sp == '0);
  assign wrIdx      = IDX_W'(sp);
  assign topIdx     = IDX_W'(sp - SP_W'(1));
  assign formed     = {page, dptr, acc};

  always_ff @(posedge clk) begin
    if (strb.pushPc && !stackFull) stackMem[wrIdx] <= pcIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp       <= '0;
      overflow <= 1'b0;
      pcLoad   <= 1'b0;
      pcOut    <= '0;
      addrReg  <= '0;
      ursFlag  <= 1'b0;
    end else begin
      if (strb.pushPc) begin
        if (stackFull) overflow <= 1'b1;
        else           sp <= sp + SP_W'(1);
      end else if (strb.popPc) begin
        sp <= sp - SP_W'(1);
      end
      pcLoad <= strb.formAddr | strb.popPc;
      if (strb.formAddr) begin
        pcOut   <= formed;
        addrReg <= formed;
      end else if (strb.popPc) begin
        pcOut <= stackMem[topIdx];
      end
      if (ursSet) ursFlag <= 1'b1;
    end
  end

  assign romRdEn = strb.readRom;
  assign romAddr = addrReg;
  assign wrAB    = strb.takeWord;
  assign bOut    = romData[2*NIB_W-1:NIB_W];
  assign aOut    = romData[NIB_W-1:0];
  assign wrCy    = strb.takeWord & ursFlag;
  assign cyOut   = romData[ROM_W-1];
endmodule

// File: rtl/rom_lookup_seq.sv
module rom_lookup_seq
  import rom_lookup_pkg::*;
#(
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PAGE_W-1:0] page,
  input  logic [DPTR_W-1:0] dptr,
  input  logic [NIB_W-1:0]  acc,
  input  logic [PC_W-1:0]   pcIn,
  input  logic              callPush,
  input  logic              retPop,
  input  logic              ursSet,
  output logic              romRdEn,
  output logic [PC_W-1:0]   romAddr,
  input  logic [ROM_W-1:0]  romData,
  output logic              busy,
  output logic              done,
  output logic              pcLoad,
  output logic [PC_W-1:0]   pcOut,
  output logic              wrAB,
  output logic [NIB_W-1:0]  bOut,
  output logic [NIB_W-1:0]  aOut,
  output logic              wrCy,
  output logic              cyOut,
  output logic              overflow
);
  seqStrobe_t strb;
  logic       stackEmpty;

  rom_lookup_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .callPush(callPush),
    .retPop(retPop), .stackEmpty(stackEmpty), .strb(strb),
    .busy(busy), .done(done)
  );

  rom_lookup_dp #(.STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .page(page), .dptr(dptr),
    .acc(acc), .pcIn(pcIn), .ursSet(ursSet), .romData(romData),
    .stackEmpty(stackEmpty), .romRdEn(romRdEn), .romAddr(romAddr),
    .pcLoad(pcLoad), .pcOut(pcOut), .wrAB(wrAB), .bOut(bOut),
    .aOut(aOut), .wrCy(wrCy), .cyOut(cyOut), .overflow(overflow)
  );
endmodule

// File: rtl/rom_lookup_chk.sv
module rom_lookup_chk
  import rom_lookup_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            pcLoad,
  input logic [PC_W-1:0] pcOut,
  input logic            romRdEn,
  input logic [PC_W-1:0] romAddr,
  input logic            wrAB,
  input logic            wrCy,
  input logic            overflow
);
  a_r2_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  a_r2_done_ends: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  a_r3_start_loads_pc: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (pcLoad && busy && !done));
  a_r4_read_at_formed: assert property (@(posedge clk) disable iff (!rstN)
    romRdEn |-> ($past(pcLoad) && romAddr == $past(pcOut)));
  a_r5_word_after_read: assert property (@(posedge clk) disable iff (!rstN)
    wrAB |-> ($past(romRdEn) && done));
  a_r6_carry_with_word: assert property (@(posedge clk) disable iff (!rstN)
    wrCy |-> wrAB);
  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
endmodule

bind rom_lookup_seq rom_lookup_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .pcLoad(pcLoad), .pcOut(pcOut), .romRdEn(romRdEn), .romAddr(romAddr),
  .wrAB(wrAB), .wrCy(wrCy), .overflow(overflow)
);

// File: tb/rom_lookup_seq_tb.sv
module rom_lookup_seq_tb;
  import rom_lookup_pkg::*;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, callPush = 1'b0, retPop = 1'b0, ursSet = 1'b0;
  logic [PAGE_W-1:0] page = '0;
  logic [DPTR_W-1:0] dptr = '0;
  logic [NIB_W-1:0]  acc = '0;
  logic [PC_W-1:0]   pcIn = '0;
  logic              romRdEn, busy, done, pcLoad, wrAB, wrCy, cyOut, overflow;
  logic [PC_W-1:0]   romAddr, pcOut;
  logic [ROM_W-1:0]  romData = '0;
  logic [NIB_W-1:0]  bOut, aOut;

  always #5 clk = ~clk;

  rom_lookup_seq #(.STACK_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .page(page), .dptr(dptr),
    .acc(acc), .pcIn(pcIn), .callPush(callPush), .retPop(retPop),
    .ursSet(ursSet), .romRdEn(romRdEn), .romAddr(romAddr),
    .romData(romData), .busy(busy), .done(done), .pcLoad(pcLoad),
    .pcOut(pcOut), .wrAB(wrAB), .bOut(bOut), .aOut(aOut), .wrCy(wrCy),
    .cyOut(cyOut), .overflow(overflow)
  );

  function automatic logic [ROM_W-1:0] romFn(input logic [PC_W-1:0] a);
    return ROM_W'((32'(a) * 7 + 32'(a >> 4) * 13 + 3) ^ 32'(a >> 2));
  endfunction

  always @(posedge clk) if (romRdEn) romData <= romFn(romAddr);

  typedef struct { int kind; int val; string req; } ev_t;
  ev_t expq[$];
  int nChecks = 0, nFails = 0;
  int mStack[DEPTH];
  int mSp = 0;
  bit mUrs = 1'b0, mOvf = 1'b0, finished = 1'b0;

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic void expect_ev(input int kind, input int val, input string req);
    ev_t e;
    e.kind = kind; e.val = val; e.req = req;
    expq.push_back(e);
  endfunction

  task automatic pop_ev(input int kind, input int val);
    ev_t e;
    nChecks++;
    if (expq.size() == 0) begin
      nFails++;
      $display("FAIL R9/R11: unexpected event kind %0d got %0h expected none", kind, val);
    end else begin
      e = expq.pop_front();
      if (e.kind != kind || e.val != val) begin
        nFails++;
        $display("FAIL %s: got kind %0d val %0h expected kind %0d val %0h",
                 e.req, kind, val, e.kind, e.val);
      end
    end
  endtask

  // monitor
  always @(negedge clk) if (rstN) begin
    if (pcLoad) pop_ev(0, int'(pcOut));
    if (wrAB)   pop_ev(1, int'({bOut, aOut}));
    if (wrCy)   pop_ev(2, int'(cyOut));
  end

  function automatic void mPush(input int v);
    if (mSp == DEPTH) mOvf = 1'b1;
    else begin mStack[mSp] = v; mSp++; end
  endfunction

  task automatic doCall(input int pc);
    @(negedge clk);
    callPush = 1'b1; pcIn = PC_W'(pc);
    mPush(pc);
    @(negedge clk);
    callPush = 1'b0;
  endtask

  task automatic doRet();
    @(negedge clk);
    retPop = 1'b1;
    if (mSp > 0) begin mSp--; expect_ev(0, mStack[mSp], "R9 ret pc"); end
    @(negedge clk);
    retPop = 1'b0;
  endtask

  task automatic doLookup(input int pg, input int dp, input int ac, input int pc,
                          input bit setUrs, input bit noise);
    int addr;
    logic [ROM_W-1:0] w;
    @(negedge clk);
    start = 1'b1; page = PAGE_W'(pg); dptr = DPTR_W'(dp); acc = NIB_W'(ac);
    pcIn = PC_W'(pc); ursSet = setUrs;
    if (noise) begin callPush = 1'b1; retPop = 1'b1; end  // R12 priority
    addr = {pg[3:0], dp[2:0], ac[3:0]};
    w = romFn(PC_W'(addr));
    mUrs = mUrs | setUrs;
    expect_ev(0, addr, "R3 formed pc");
    mPush(pc);
    mSp--;
    expect_ev(0, mStack[mSp], "R8 restored pc");
    expect_ev(1, int'(w[7:0]), "R5 B/A split");
    if (mUrs) expect_ev(2, int'(w[8]), "R6/R7 carry");
    @(negedge clk);   // first busy cycle
    start = 1'b0; ursSet = 1'b0; callPush = 1'b0; retPop = 1'b0;
    if (noise) begin start = 1'b1; callPush = 1'b1; retPop = 1'b1; end  // R11
    check("R2 busy c1", int'(busy), 1);
    check("R4 no read c1", int'(romRdEn), 0);
    @(negedge clk);   // second busy cycle
    check("R4 read enable", int'(romRdEn), 1);
    check("R4 read addr", int'(romAddr), addr);
    check("R2 no done c2", int'(done), 0);
    @(negedge clk);   // third busy cycle
    check("R2 done c3", int'(done), 1);
    start = 1'b0; callPush = 1'b0; retPop = 1'b0;
    @(negedge clk);
    check("R2 idle after", int'(busy), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 pcLoad", int'(pcLoad), 0);
    check("R1 romRdEn", int'(romRdEn), 0);
    check("R1 wrAB/wrCy", int'({wrAB, wrCy}), 0);
    check("R1 overflow", int'(overflow), 0);
    // R9 return on empty stack
    doRet();
    check("R9 empty ret no load", int'(pcLoad), 0);
    doCall('h123);
    doCall('h456);
    // lookups, mode flag clear (R6 no carry)
    doLookup(4'h3, 3'h5, 4'hA, 'h0F0, 1'b0, 1'b0);
    doLookup(4'hF, 3'h7, 4'hF, 'h7FF, 1'b0, 1'b0);
    doLookup(4'h0, 3'h0, 4'h0, 'h001, 1'b0, 1'b0);
    // R11/R12 requests while busy or together with start
    doLookup(4'h9, 3'h2, 4'h6, 'h2AA, 1'b0, 1'b1);
    // R7 mode flag set in the start cycle
    doLookup(4'h5, 3'h1, 4'hC, 'h333, 1'b1, 1'b0);
    doLookup(4'hA, 3'h6, 4'h3, 'h444, 1'b0, 1'b0);
    doLookup(4'h7, 3'h4, 4'h9, 'h555, 1'b0, 1'b0);
    doRet();
    doRet();
    @(negedge clk);
    check("R8 stack balanced", expq.size(), 0);
    // R10 fill stack and overflow
    for (int i = 0; i < DEPTH; i++) doCall('h100 + i * 17);
    @(negedge clk);
    check("R10 full no overflow", int'(overflow), 0);
    doCall('h7AB);
    @(negedge clk);
    check("R10 overflow set", int'(overflow), 1);
    doLookup(4'h2, 3'h3, 4'h4, 'h666, 1'b0, 1'b0);
    check("R10 overflow sticky", int'(overflow), 1);
    for (int i = 0; i < DEPTH; i++) doRet();
    doRet();
    repeat (2) @(negedge clk);
    check("R9 all events seen", expq.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule